// File: doc/BRIEF.md
# Three-Step Combination Lock Controller

This block is the sequencing controller of a digital door lock. A user enters code values one at a time. An external comparator checks each value against the code word that the controller currently selects, and it raises a single equality bit. The controller opens the lock only after the first, second and third code words have each been matched, in that order. A wrong value at any point sends the controller into an error condition. The lock stays closed there and ignores all further entries until a start pulse restarts the sequence.

The state register is the output. Its low bits form a one-hot select that drives the external code-word multiplexer, and its top bit is the lock-open control. The error condition is the all-zero pattern. It is not a separate encoded state: synchronous preset and clear terms on the same flip-flops reach it. There is no separate output decoder, so every output comes directly from a flip-flop. Each entered value arrives as a one-cycle `new_val` strobe, and `match` is valid in that same cycle. The interface carries no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first start, the state is the error pattern: `code_sel` = 000 and `lock_open` = 0.
- R2: A clock edge with `start` high loads the first-code state: `code_sel` = 001 (bit 0 selects code one), `lock_open` = 0. This happens whatever `new_val` and `match` are.
- R3: The four state bits {`lock_open`, `code_sel[2:0]`} never have more than one bit set. `code_sel` bit 1 selects code two, bit 2 selects code three, and `lock_open` set means the lock is open.
- R4: With `start` low, a clock edge with `new_val` and `match` both high advances the state by one step. The steps are 001 to 010, 010 to 100, and 100 to open (`lock_open` = 1, `code_sel` = 000).
- R5: With `start` low and `new_val` low, any non-error state holds unchanged.
- R6: With `start` low, a clock edge with `new_val` high and `match` low clears every state bit, which gives the error pattern. This applies in the three code states and in the open state.
- R7: In the error pattern with `start` low, the state stays all-zero whatever `new_val` and `match` are.
- R8: The open state holds while `new_val` is low, and also on a strobe with `match` high.
- R9: `start` has priority over the error clear. `start` together with a mismatching strobe still loads the first-code state.
- R10: After an error, correct values have no effect until a start. After a start, three correct values open the lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset; forces the error pattern |
| start | input | 1 | Synchronous restart to the first-code state |
| new_val | input | 1 | One-cycle strobe: an entered value is present |
| match | input | 1 | Comparator result for the entered value against the selected code |
| code_sel | output | NUM_CODES | One-hot code-word multiplexer select, straight from the state flops |
| lock_open | output | 1 | Lock-open control, the top state flop |

## Verification
The outputs are the state bits themselves. A corrupted next-state or preset/clear term therefore shows up at `code_sel` or `lock_open` on the very clock edge where the wrong value is registered. Because of this, the bench compares the full four-bit pattern after every edge. A wrong-priority fault between start and the error clear shows up only when start meets a mismatching strobe, so that case is driven on purpose. A fault that lets the error pattern leak shows up only when correct values are entered during an error, so that case is driven too.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;

  // Control terms applied to the state flops at a clock edge.
  typedef struct packed {
    logic preset;  // load the first-code state
    logic clear;   // force the all-zero error pattern
  } lock_ctl_t;

  // State pattern with only the first select bit set.
  function automatic logic [31:0] first_state_pattern();
    return 32'd1;
  endfunction

endpackage

// File: rtl/combo_lock_next.sv
module combo_lock_next #(
  parameter int unsigned NUM_CODES = 3
) (
  input  logic [NUM_CODES:0] state_q,
  input  logic               new_val,
  input  logic               match,
  output logic [NUM_CODES:0] state_d
);
  localparam int unsigned SW = NUM_CODES + 1;

  logic step;
  assign step = new_val & match;

  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (i == 0) begin : g_first
      // The first-code state holds until a value arrives.
      assign state_d[i] = state_q[i] & ~new_val;
    end else if (i == SW - 1) begin : g_open
      // The open bit is entered from the last code and then stays set.
      assign state_d[i] = (state_q[i-1] & step) | state_q[i];
    end else begin : g_mid
      assign state_d[i] = (state_q[i-1] & step) | (state_q[i] & ~new_val);
    end
  end

endmodule

// File: rtl/combo_lock_guard.sv
module combo_lock_guard
  import combo_lock_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  logic          start,
  input  logic          new_val,
  input  logic          match,
  input  logic [SW-1:0] state_q,
  output lock_ctl_t     ctl
);
  logic bad_entry;
  logic in_error;

  assign bad_entry = new_val & ~match;
  assign in_error  = ~|state_q;

  // Start wins; otherwise a mismatch or an existing error keeps the bits clear.
  assign ctl.preset = start;
  assign ctl.clear  = ~start & (bad_entry | in_error);

endmodule

// File: rtl/combo_lock_statereg.sv
module combo_lock_statereg
  import combo_lock_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lock_ctl_t     ctl,
  input  logic [SW-1:0] state_d,
  output logic [SW-1:0] state_q
);
  localparam logic [31:0] FIRST = first_state_pattern();

  for (genvar i = 0; i < SW; i++) begin : g_ff
    localparam logic PRESET_VAL = FIRST[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state_q[i] <= 1'b0;
      end else if (ctl.preset) begin
        state_q[i] <= PRESET_VAL;
      end else if (ctl.clear) begin
        state_q[i] <= 1'b0;
      end else begin
        state_q[i] <= state_d[i];
      end
    end
  end

endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import combo_lock_pkg::*;
#(
  parameter int unsigned NUM_CODES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 new_val,
  input  logic                 match,
  output logic [NUM_CODES-1:0] code_sel,
  output logic                 lock_open
);
  localparam int unsigned SW = NUM_CODES + 1;

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  lock_ctl_t     ctl;

  combo_lock_next #(.NUM_CODES(NUM_CODES)) u_next (
    .state_q (state_q),
    .new_val (new_val),
    .match   (match),
    .state_d (state_d)
  );

  combo_lock_guard #(.SW(SW)) u_guard (
    .start   (start),
    .new_val (new_val),
    .match   (match),
    .state_q (state_q),
    .ctl     (ctl)
  );

  combo_lock_statereg #(.SW(SW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .state_d (state_d),
    .state_q (state_q)
  );

  // Output encoding: the flops are the outputs.
  assign code_sel  = state_q[NUM_CODES-1:0];
  assign lock_open = state_q[NUM_CODES];

endmodule

// File: rtl/combo_lock_ctrl_chk.sv
module combo_lock_ctrl_chk #(
  parameter int unsigned NUM_CODES = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 new_val,
  input logic                 match,
  input logic [NUM_CODES-1:0] code_sel,
  input logic                 lock_open
);
  logic [NUM_CODES:0] st;
  assign st = {lock_open, code_sel};

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st)); // R3

  AST_START_LOADS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == (NUM_CODES+1)'(1))); // R2 R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !new_val && (st != '0)) |=> $stable(st)); // R5

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && new_val && match && (code_sel != '0)) |=> (st == ($past(st) << 1))); // R4

  AST_MISMATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && new_val && !match) |=> (st == '0)); // R6

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (st == '0)) |=> (st == '0)); // R7 R10

  AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && lock_open && (!new_val || match)) |=> lock_open); // R8

  always_comb begin
    if (!rst_n) begin
      AST_RESET_ERROR: assert (st == '0 || $isunknown(st)); // R1
    end
  end

endmodule

bind combo_lock_ctrl combo_lock_ctrl_chk #(.NUM_CODES(NUM_CODES)) u_chk (.*);

// File: tb/combo_lock_ctrl_tb_top.sv
module combo_lock_ctrl_tb_top;
  localparam logic [3:0] C1 = 4'h5;
  localparam logic [3:0] C2 = 4'h9;
  localparam logic [3:0] C3 = 4'h3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       new_val = 1'b0;
  logic       force_eq = 1'b0;
  logic [3:0] entry = 4'h0;
  logic [2:0] code_sel;
  logic       lock_open;
  logic       match;
  logic [3:0] sel_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [3:0] exp_state = 4'h0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  // Test wrappers: code-word multiplexer and comparator.
  always_comb begin
    if (code_sel[0])      sel_code = C1;
    else if (code_sel[1]) sel_code = C2;
    else if (code_sel[2]) sel_code = C3;
    else                  sel_code = 4'h0;
  end
  assign match = force_eq | ((code_sel != 3'b000) && (entry == sel_code));

  combo_lock_ctrl #(.NUM_CODES(3)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .new_val   (new_val),
    .match     (match),
    .code_sel  (code_sel),
    .lock_open (lock_open)
  );

  function automatic logic [3:0] code_for(input logic [3:0] s);
    if (s[0]) return C1;
    if (s[1]) return C2;
    if (s[2]) return C3;
    return 4'h0;
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected state.
  task automatic step(input bit st, input bit nv, input bit right, input bit feq, input string tag);
    logic [3:0] val;
    logic       m;
    @(negedge clk);
    val      = right ? code_for(exp_state) : (code_for(exp_state) ^ 4'hA);
    start    = st;
    new_val  = nv;
    entry    = val;
    force_eq = feq;
    m = feq | ((exp_state[2:0] != 3'b000) && (val == code_for(exp_state)));
    if (st)                     exp_state = 4'b0001;
    else if (exp_state == 4'h0) exp_state = 4'h0;
    else if (nv && !m)          exp_state = 4'h0;
    else if (nv && m)           exp_state = exp_state[3] ? 4'b1000 : (exp_state << 1);
    exp_q.push_back(exp_state);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the outputs after each edge against the queue.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {lock_open, code_sel}, e);
        check("R3 at most one bit", {3'b000, ($countones({lock_open, code_sel}) <= 1)}, 4'h1);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 during reset", {lock_open, code_sel}, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R1 after release", {lock_open, code_sel}, 4'h0);

    // R7: error pattern ignores entries
    step(0, 1, 1, 0, "R7 right value in error");
    step(0, 1, 0, 1, "R7 forced match in error");
    step(0, 0, 0, 0, "R7 idle in error");

    // R2 R4 R5 R8: full opening sequence
    step(1, 0, 0, 0, "R2 start");
    step(0, 0, 0, 0, "R5 hold first");
    step(0, 1, 1, 0, "R4 first to second");
    step(0, 0, 0, 0, "R5 hold second");
    step(0, 1, 1, 0, "R4 second to third");
    step(0, 1, 1, 0, "R4 third to open");
    step(0, 0, 0, 0, "R8 open idle");
    step(0, 1, 0, 1, "R8 open matching strobe");
    step(0, 1, 0, 0, "R6 open mismatch");

    // R9: start beats the error clear
    step(1, 1, 0, 0, "R9 start with mismatch");
    step(0, 1, 0, 0, "R6 mismatch in first");
    step(1, 0, 0, 0, "R2 restart");
    step(0, 1, 1, 0, "R4 advance");
    step(0, 1, 0, 0, "R6 mismatch in second");
    step(1, 0, 0, 0, "R2 restart");
    step(0, 1, 1, 0, "R4 advance");
    step(0, 1, 1, 0, "R4 advance");
    step(0, 1, 0, 0, "R6 mismatch in third");

    // R10: recovery only through start
    step(0, 1, 1, 0, "R10 right value after error");
    step(0, 1, 0, 1, "R10 forced match after error");
    step(1, 1, 1, 0, "R10 start");
    step(0, 1, 1, 0, "R10 first");
    step(0, 1, 1, 0, "R10 second");
    step(0, 1, 1, 0, "R10 third opens");
    step(0, 0, 0, 0, "R8 open holds");

    step(0, 0, 0, 0, "R8 open drain");
    while (exp_q.size() > 0) @(posedge clk);
    #6;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule